// File: doc/BRIEF.md
# Fetch Block Instruction Predecoder

This block looks at one fetch block presented as 17 consecutive 16-bit halfwords and, for each of the first 16 halfword positions, works out what an instruction starting there would be. For every position it forms the 32-bit raw word made from that halfword and the one above it. It then reports whether that word is a compressed instruction, whether it is a control-flow instruction and of which kind, whether it acts as a call or a return, and the signed jump offset carried in its immediate.

Instruction boundaries depend on where the block starts. The block builds two start vectors side by side. One assumes the first halfword opens an instruction. The other assumes the first halfword is the upper half of a 32-bit instruction that began in the previous block. A later pipeline stage picks one of them with its carried-over half-instruction flag. Per-position decode is done for every position whether or not it turns out to be a start, so the choice between vectors needs no re-decode. The block is purely combinational.

Top module: `fetch_predecoder`

## Requirements
- R1: The raw word for position i equals halfword i in bits 15:0 and halfword i+1 in bits 31:16.
- R2: A position is compressed exactly when bits 1:0 of its halfword are not 2'b11.
- R3: Start vector A marks position 0 as a start. Each later position is a start unless the position just below it is a start of a 32-bit (non-compressed) instruction.
- R4: Start vector B marks position 0 as not a start and position 1 as a start. From position 2 upward it follows the same rule as R3.
- R5: The type code is 2'b01 (branch) for a 32-bit word with opcode 7'b1100011, and for a compressed word in quadrant 2'b01 with funct3 3'b110 or 3'b111.
- R6: The type code is 2'b10 (direct jump) for a 32-bit word with opcode 7'b1101111, and for a compressed word in quadrant 2'b01 with funct3 3'b101 or 3'b001.
- R7: The type code is 2'b11 (indirect jump) for a 32-bit word with opcode 7'b1100111 and funct3 3'b000. It is also 2'b11 for a compressed word in quadrant 2'b10 with funct3 3'b100, bits 6:2 zero and bits 11:7 nonzero. Every other word has type code 2'b00.
- R8: The control-flow flag of a position is set exactly when its type code is not 2'b00.
- R9: The call flag is set for a 32-bit direct or indirect jump whose rd (bits 11:7) is 1 or 5. It is set for a compressed jump with funct3 3'b001, and for a compressed indirect jump with bit 12 set.
- R10: The return flag is set for a 32-bit indirect jump whose rs1 (bits 19:15) is 1 or 5 and whose rd is neither 1 nor 5. It is set for a compressed indirect jump with bit 12 clear and bits 11:7 equal to 1 or 5.
- R11: The offset is the sign-extended immediate for 32-bit direct jumps and branches, and for compressed direct jumps and branches, as the standard encodings scatter it. The offset is zero for indirect jumps and for words that are not control flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hwIn | input | 272 | 17 halfwords; halfword k in bits 16k+15:16k |
| rawOut | output | 512 | Raw 32-bit word per position, position i in bits 32i+31:32i |
| startVecA | output | 16 | Start vector assuming the block opens on a boundary |
| startVecB | output | 16 | Start vector assuming the block opens mid-instruction |
| compressedVec | output | 16 | Compressed flag per position |
| cfiVec | output | 16 | Control-flow flag per position |
| cfiTypeOut | output | 32 | Type code per position, position i in bits 2i+1:2i |
| callVec | output | 16 | Call flag per position |
| retVec | output | 16 | Return flag per position |
| offsetOut | output | 512 | Signed jump offset per position, position i in bits 32i+31:32i |

## Verification
The assertions assume every bit of the halfword input is known. They are skipped while any input bit is X. They also assume at least two positions, so that both origins of vector B exist. The bench drives fully defined halfwords at all times, starting from an all-zero block. It changes the input only on the falling clock edge, so each evaluation sees one stable, known block. The directed blocks and the pool-based blocks are built only from defined 16-bit values, and only the default position count is used.

// File: rtl/predec_pkg.sv
package predec_pkg;

  localparam int HW_BITS   = 16;
  localparam int WORD_BITS = 32;

  typedef enum logic [1:0] {
    CFI_NONE   = 2'b00,
    CFI_BRANCH = 2'b01,
    CFI_JAL    = 2'b10,
    CFI_JALR   = 2'b11
  } cfiKind_e;

  typedef struct packed {
    logic                 compressed;
    logic                 isCfi;
    cfiKind_e             kind;
    logic                 isCall;
    logic                 isRet;
    logic [WORD_BITS-1:0] offset;
  } slotInfo_t;

  // strobe handed from the datapath to the boundary control
  typedef struct packed {
    logic compressed;
  } slotStrobe_t;

  function automatic logic isLinkReg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

endpackage

// File: rtl/predec_slot.sv
module predec_slot
  import predec_pkg::*;
(
  input  logic [WORD_BITS-1:0] rawWord,
  output slotInfo_t            info
);

  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic [4:0]  rdField;
  logic [4:0]  rs1Field;
  logic [1:0]  cQuad;
  logic [2:0]  cFunct3;
  logic [4:0]  cRegHi;
  logic [4:0]  cRegLo;
  logic [WORD_BITS-1:0] immJal;
  logic [WORD_BITS-1:0] immBr;
  logic [WORD_BITS-1:0] immCj;
  logic [WORD_BITS-1:0] immCb;

  assign opcode   = rawWord[6:0];
  assign funct3   = rawWord[14:12];
  assign rdField  = rawWord[11:7];
  assign rs1Field = rawWord[19:15];
  assign cQuad    = rawWord[1:0];
  assign cFunct3  = rawWord[15:13];
  assign cRegHi   = rawWord[11:7];
  assign cRegLo   = rawWord[6:2];

  assign immJal = {{12{rawWord[31]}}, rawWord[19:12], rawWord[20], rawWord[30:21], 1'b0};
  assign immBr  = {{20{rawWord[31]}}, rawWord[7], rawWord[30:25], rawWord[11:8], 1'b0};
  assign immCj  = {{21{rawWord[12]}}, rawWord[8], rawWord[10:9], rawWord[6], rawWord[7],
                   rawWord[2], rawWord[11], rawWord[5:3], 1'b0};
  assign immCb  = {{24{rawWord[12]}}, rawWord[6:5], rawWord[2], rawWord[11:10],
                   rawWord[4:3], 1'b0};

  always_comb begin
    info            = '0;
    info.kind       = CFI_NONE;
    info.compressed = (cQuad != 2'b11);
    if (!info.compressed) begin
      unique case (opcode)
        7'b1101111: begin
          info.kind   = CFI_JAL;
          info.isCfi  = 1'b1;
          info.isCall = isLinkReg(rdField);
          info.offset = immJal;
        end
        7'b1100111: begin
          if (funct3 == 3'b000) begin
            info.kind   = CFI_JALR;
            info.isCfi  = 1'b1;
            info.isCall = isLinkReg(rdField);
            info.isRet  = isLinkReg(rs1Field) && !isLinkReg(rdField);
          end
        end
        7'b1100011: begin
          info.kind   = CFI_BRANCH;
          info.isCfi  = 1'b1;
          info.offset = immBr;
        end
        default: ;
      endcase
    end else if (cQuad == 2'b01) begin
      unique case (cFunct3)
        3'b101: begin
          info.kind   = CFI_JAL;
          info.isCfi  = 1'b1;
          info.offset = immCj;
        end
        3'b001: begin
          info.kind   = CFI_JAL;
          info.isCfi  = 1'b1;
          info.isCall = 1'b1;
          info.offset = immCj;
        end
        3'b110, 3'b111: begin
          info.kind   = CFI_BRANCH;
          info.isCfi  = 1'b1;
          info.offset = immCb;
        end
        default: ;
      endcase
    end else if (cQuad == 2'b10 && cFunct3 == 3'b100 && cRegLo == 5'd0 && cRegHi != 5'd0) begin
      info.kind  = CFI_JALR;
      info.isCfi = 1'b1;
      if (rawWord[12]) begin
        info.isCall = 1'b1;
      end else begin
        info.isRet = isLinkReg(cRegHi);
      end
    end
  end

endmodule

// File: rtl/predec_datapath.sv
module predec_datapath
  import predec_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic [(NUM_SLOTS+1)*HW_BITS-1:0] hwIn,
  output logic [NUM_SLOTS*WORD_BITS-1:0]   rawOut,
  output slotInfo_t [NUM_SLOTS-1:0]        infoOut,
  output slotStrobe_t [NUM_SLOTS-2:0]      strobeOut
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [WORD_BITS-1:0] word;
    assign word = hwIn[s*HW_BITS +: WORD_BITS];
    assign rawOut[s*WORD_BITS +: WORD_BITS] = word;

    predec_slot u_slot (
      .rawWord (word),
      .info    (infoOut[s])
    );

    if (s < NUM_SLOTS-1) begin : g_strobe
      assign strobeOut[s].compressed = infoOut[s].compressed;
    end
  end

endmodule

// File: rtl/predec_boundary.sv
module predec_boundary
  import predec_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  slotStrobe_t [NUM_SLOTS-2:0] strobeIn,
  output logic [NUM_SLOTS-1:0]        startA,
  output logic [NUM_SLOTS-1:0]        startB
);

  assign startA[0] = 1'b1;
  assign startB[0] = 1'b0;
  assign startB[1] = 1'b1;

  for (genvar p = 1; p < NUM_SLOTS; p++) begin : g_chainA
    assign startA[p] = !startA[p-1] || strobeIn[p-1].compressed;
  end

  for (genvar p = 2; p < NUM_SLOTS; p++) begin : g_chainB
    assign startB[p] = !startB[p-1] || strobeIn[p-1].compressed;
  end

endmodule

// File: rtl/fetch_predecoder.sv
module fetch_predecoder
  import predec_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic [(NUM_SLOTS+1)*16-1:0] hwIn,
  output logic [NUM_SLOTS*32-1:0]     rawOut,
  output logic [NUM_SLOTS-1:0]        startVecA,
  output logic [NUM_SLOTS-1:0]        startVecB,
  output logic [NUM_SLOTS-1:0]        compressedVec,
  output logic [NUM_SLOTS-1:0]        cfiVec,
  output logic [NUM_SLOTS*2-1:0]      cfiTypeOut,
  output logic [NUM_SLOTS-1:0]        callVec,
  output logic [NUM_SLOTS-1:0]        retVec,
  output logic [NUM_SLOTS*32-1:0]     offsetOut
);

  slotInfo_t   [NUM_SLOTS-1:0] slotInfo;
  slotStrobe_t [NUM_SLOTS-2:0] slotStrobe;

  predec_datapath #(.NUM_SLOTS(NUM_SLOTS)) u_datapath (
    .hwIn      (hwIn),
    .rawOut    (rawOut),
    .infoOut   (slotInfo),
    .strobeOut (slotStrobe)
  );

  predec_boundary #(.NUM_SLOTS(NUM_SLOTS)) u_boundary (
    .strobeIn (slotStrobe),
    .startA   (startVecA),
    .startB   (startVecB)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_out
    assign compressedVec[s]      = slotInfo[s].compressed;
    assign cfiVec[s]             = slotInfo[s].isCfi;
    assign cfiTypeOut[2*s +: 2]  = slotInfo[s].kind;
    assign callVec[s]            = slotInfo[s].isCall;
    assign retVec[s]             = slotInfo[s].isRet;
    assign offsetOut[32*s +: 32] = slotInfo[s].offset;
  end

endmodule

// File: rtl/predec_checker.sv
module predec_checker #(
  parameter int NUM_SLOTS = 16
) (
  input logic [(NUM_SLOTS+1)*16-1:0] hwIn,
  input logic [NUM_SLOTS*32-1:0]     rawOut,
  input logic [NUM_SLOTS-1:0]        startVecA,
  input logic [NUM_SLOTS-1:0]        startVecB,
  input logic [NUM_SLOTS-1:0]        compressedVec,
  input logic [NUM_SLOTS-1:0]        cfiVec,
  input logic [NUM_SLOTS*2-1:0]      cfiTypeOut,
  input logic [NUM_SLOTS-1:0]        callVec,
  input logic [NUM_SLOTS-1:0]        retVec,
  input logic [NUM_SLOTS*32-1:0]     offsetOut
);

  always_comb begin
    if (!$isunknown(hwIn)) begin
      // R3
      startA_origin_chk: assert (startVecA[0]);
      // R4
      startB_origin_chk: assert (!startVecB[0] && startVecB[1]);
      for (int i = 0; i < NUM_SLOTS-1; i++) begin
        // R3
        startA_upper_chk: assert (!(startVecA[i] && !compressedVec[i]) || !startVecA[i+1]);
        // R3
        startA_gap_chk: assert (startVecA[i] || startVecA[i+1]);
      end
      for (int i = 1; i < NUM_SLOTS-1; i++) begin
        // R4
        startB_upper_chk: assert (!(startVecB[i] && !compressedVec[i]) || !startVecB[i+1]);
      end
      for (int i = 0; i < NUM_SLOTS; i++) begin
        // R2
        compressed_bits_chk: assert (compressedVec[i] == (rawOut[32*i +: 2] != 2'b11));
        // R8
        cfi_flag_chk: assert (cfiVec[i] == (cfiTypeOut[2*i +: 2] != 2'b00));
        // R9
        call_type_chk: assert (!callVec[i] || cfiTypeOut[2*i+1]);
        // R10
        ret_type_chk: assert (!retVec[i] || (cfiTypeOut[2*i +: 2] == 2'b11 && !callVec[i]));
        // R11
        offset_zero_chk: assert (cfiTypeOut[2*i] != cfiTypeOut[2*i+1] || offsetOut[32*i +: 32] == 32'd0);
      end
    end
  end

endmodule

bind fetch_predecoder predec_checker #(.NUM_SLOTS(NUM_SLOTS)) u_predec_checker (
  .hwIn          (hwIn),
  .rawOut        (rawOut),
  .startVecA     (startVecA),
  .startVecB     (startVecB),
  .compressedVec (compressedVec),
  .cfiVec        (cfiVec),
  .cfiTypeOut    (cfiTypeOut),
  .callVec       (callVec),
  .retVec        (retVec),
  .offsetOut     (offsetOut)
);

// File: tb/fetch_predecoder_bench.sv
module fetch_predecoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 16;
  localparam int HWS        = SLOTS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] hw [HWS];
  logic [HWS*16-1:0]   hwIn;
  logic [SLOTS*32-1:0] rawOut;
  logic [SLOTS-1:0]    startVecA, startVecB, compressedVec, cfiVec, callVec, retVec;
  logic [SLOTS*2-1:0]  cfiTypeOut;
  logic [SLOTS*32-1:0] offsetOut;

  for (genvar g = 0; g < HWS; g++) begin : g_pack
    assign hwIn[g*16 +: 16] = hw[g];
  end

  fetch_predecoder #(.NUM_SLOTS(SLOTS)) u_fetch_predecoder (
    .hwIn          (hwIn),
    .rawOut        (rawOut),
    .startVecA     (startVecA),
    .startVecB     (startVecB),
    .compressedVec (compressedVec),
    .cfiVec        (cfiVec),
    .cfiTypeOut    (cfiTypeOut),
    .callVec       (callVec),
    .retVec        (retVec),
    .offsetOut     (offsetOut)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  initial begin
    for (int k = 0; k < HWS; k++) hw[k] = 16'h0000;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit linkReg(input logic [4:0] r);
    return r == 5'd1 || r == 5'd5;
  endfunction

  // reference model written from the requirements
  function automatic void refSlot(input logic [31:0] w, output bit rvc, output logic [1:0] t,
                                  output bit call, output bit ret, output logic [31:0] off);
    logic [15:0] c;
    c = w[15:0];
    rvc = (w[1:0] != 2'b11);
    t = 2'b00; call = 0; ret = 0; off = 32'd0;
    if (!rvc) begin
      if (w[6:0] == 7'b1100011) begin
        t = 2'b01;
        off = {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
      end else if (w[6:0] == 7'b1101111) begin
        t = 2'b10; call = linkReg(w[11:7]);
        off = {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
      end else if (w[6:0] == 7'b1100111 && w[14:12] == 3'b000) begin
        t = 2'b11; call = linkReg(w[11:7]);
        ret = linkReg(w[19:15]) && !linkReg(w[11:7]);
      end
    end else if (c[1:0] == 2'b01 && (c[15:13] == 3'b110 || c[15:13] == 3'b111)) begin
      t = 2'b01;
      off = {{24{c[12]}}, c[6:5], c[2], c[11:10], c[4:3], 1'b0};
    end else if (c[1:0] == 2'b01 && (c[15:13] == 3'b101 || c[15:13] == 3'b001)) begin
      t = 2'b10; call = (c[15:13] == 3'b001);
      off = {{21{c[12]}}, c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b100 && c[6:2] == 5'd0 && c[11:7] != 5'd0) begin
      t = 2'b11;
      call = c[12];
      ret = !c[12] && linkReg(c[11:7]);
    end
  endfunction

  task automatic compareModel(input string scen);
    logic [SLOTS-1:0] expA, expB, expRvc, expCfi, expCall, expRet;
    logic [SLOTS*2-1:0] expType;
    int pos;
    for (int i = 0; i < SLOTS; i++) begin
      bit rvc, call, ret;
      logic [1:0] t;
      logic [31:0] off;
      refSlot({hw[i+1], hw[i]}, rvc, t, call, ret, off);
      expRvc[i] = rvc; expCfi[i] = (t != 2'b00); expType[2*i +: 2] = t;
      expCall[i] = call; expRet[i] = ret;
      chk("R1", $sformatf("%s raw[%0d]", scen, i), 64'(rawOut[32*i +: 32]), 64'({hw[i+1], hw[i]}));
      chk("R11", $sformatf("%s offset[%0d]", scen, i), 64'(offsetOut[32*i +: 32]), 64'(off));
    end
    expA = '0; pos = 0;
    while (pos < SLOTS) begin expA[pos] = 1'b1; pos += expRvc[pos] ? 1 : 2; end
    expB = '0; pos = 1;
    while (pos < SLOTS) begin expB[pos] = 1'b1; pos += expRvc[pos] ? 1 : 2; end
    chk("R2", {scen, " compressed"}, 64'(compressedVec), 64'(expRvc));
    chk("R3", {scen, " startA"}, 64'(startVecA), 64'(expA));
    chk("R4", {scen, " startB"}, 64'(startVecB), 64'(expB));
    chk("R5_R6_R7", {scen, " type"}, 64'(cfiTypeOut), 64'(expType));
    chk("R8", {scen, " cfi"}, 64'(cfiVec), 64'(expCfi));
    chk("R9", {scen, " call"}, 64'(callVec), 64'(expCall));
    chk("R10", {scen, " ret"}, 64'(retVec), 64'(expRet));
  endtask

  task automatic applyBlock();
    #1;
  endtask

  task automatic testZeroBlock();
    @(negedge clk);
    for (int k = 0; k < HWS; k++) hw[k] = 16'h0000;
    applyBlock();
    chk("R3", "zero startA", 64'(startVecA), 64'hFFFF);
    chk("R4", "zero startB", 64'(startVecB), 64'hFFFE);
    chk("R8", "zero cfi", 64'(cfiVec), 64'h0);
    compareModel("zero");
  endtask

  task automatic testAllWide();
    @(negedge clk);
    for (int k = 0; k < HWS; k++) hw[k] = (k % 2 == 0) ? 16'h0013 : 16'h0003;
    applyBlock();
    chk("R3", "wide startA", 64'(startVecA), 64'h5555);
    chk("R4", "wide startB", 64'(startVecB), 64'hAAAA);
    chk("R2", "wide compressed", 64'(compressedVec), 64'h0);
    compareModel("wide");
  endtask

  task automatic testJumps();
    @(negedge clk);
    for (int k = 0; k < HWS; k++) hw[k] = 16'h0001;
    hw[0] = 16'h00EF; hw[1] = 16'h0080;   // jal x1,+8
    hw[2] = 16'h8067; hw[3] = 16'h0000;   // jalr x0,0(x1)
    hw[4] = 16'h0EE3; hw[5] = 16'hFE00;   // beq x0,x0,-4
    hw[6] = 16'hBFFD;                     // c.j -2
    hw[7] = 16'h8082;                     // c.jr x1
    hw[8] = 16'h9282;                     // c.jalr x5
    applyBlock();
    chk("R6", "jal type", 64'(cfiTypeOut[1:0]), 64'h2);
    chk("R9", "jal call", 64'(callVec[0]), 64'h1);
    chk("R11", "jal offset", 64'(offsetOut[31:0]), 64'h8);
    chk("R7", "jalr type", 64'(cfiTypeOut[5:4]), 64'h3);
    chk("R10", "jalr ret", 64'(retVec[2]), 64'h1);
    chk("R11", "jalr offset", 64'(offsetOut[95:64]), 64'h0);
    chk("R5", "beq type", 64'(cfiTypeOut[9:8]), 64'h1);
    chk("R11", "beq offset", 64'(offsetOut[159:128]), 64'hFFFFFFFC);
    chk("R11", "c.j offset", 64'(offsetOut[223:192]), 64'hFFFFFFFE);
    chk("R10", "c.jr ret", 64'(retVec[7]), 64'h1);
    chk("R9", "c.jalr call", 64'(callVec[8]), 64'h1);
    chk("R10", "c.jalr not ret", 64'(retVec[8]), 64'h0);
    chk("R3", "mixed startA", 64'(startVecA), 64'hFFD5);
    compareModel("jumps");
  endtask

  task automatic testPoolStreams();
    logic [15:0] pool [12];
    pool = '{16'h00EF, 16'h8067, 16'h0EE3, 16'hBFFD, 16'h8082, 16'h9282,
             16'hC001, 16'h2001, 16'h0013, 16'h0001, 16'h80E7, 16'h82E7};
    for (int it = 0; it < 60; it++) begin
      @(negedge clk);
      for (int k = 0; k < HWS; k++) begin
        hw[k] = ($urandom_range(0, 2) == 0) ? 16'($urandom) : pool[$urandom_range(0, 11)];
      end
      applyBlock();
      compareModel($sformatf("pool%0d", it));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testZeroBlock();
    testAllWide();
    testJumps();
    testPoolStreams();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule